// File: doc/BRIEF.md
# Multicycle Processor Sequencing Controller

This block is the sequencing controller for a multicycle processor core. The core has one shared memory and one ALU, and the controller drives that datapath from a single twelve-state Moore machine. Every instruction starts with two common cycles. The first fetches the instruction and advances the program counter. The second decodes the opcode and reads the register operands while the ALU speculatively forms a branch target. After these two cycles, the machine follows a class-specific sequence of one to three cycles and then returns to fetch.

Two further states handle faults. The first catches an opcode that matches no supported class. The second catches a signed overflow reported by the ALU while an R-type operation executes. Both states make the ALU form PC minus 4 so that the faulting instruction's address is stored in the return-address register. They also record a reason code and load the PC from the fixed handler vector.

All control outputs are registered. The controller decodes the state it is about to enter, so the outputs always match the current state with no combinational path from inputs to outputs. The only inputs are the 6-bit opcode, held by the datapath's instruction register, and the ALU overflow flag.

Top module: `mc_ctrl_fsm`

## Requirements
- R1: While reset is high, and in the first cycle after reset, the outputs show the fetch control word. A reset asserted in the middle of an instruction returns the machine to fetch at the next edge.
- R2: Fetch state drives these signals high: ram_rd, instr_latch and pc_load. It drives opb_sel=01, opa_sel=0, addr_from_alu=0, alu_mode=00 and pc_mux=00. The next state is always decode.
- R3: Decode state drives opb_sel=11, with opa_sel=0 and alu_mode=00. It then dispatches on the opcode, as listed below. Any other opcode goes to the undefined-opcode state.
  - 100011 (load) and 101011 (store) go to address calculation.
  - 000000 (R-type) goes to execute.
  - 000100 (branch-equal) goes to branch completion.
  - 000010 (jump) goes to jump completion.
- R4: Address-calculation state drives opa_sel=1, opb_sel=10 and alu_mode=00. It then goes to the memory-read state for a load and to the memory-write state for a store.
- R5: The memory-read state drives ram_rd=1 with addr_from_alu=1, and is followed by the load write-back state. The load write-back state drives rf_we=1 with rf_dst_rd=0 and rf_from_mem=1.
- R6: The memory-write state drives ram_wr=1 with addr_from_alu=1. The machine never reads and writes memory in the same cycle.
- R7: Execute state drives opa_sel=1, opb_sel=00 and alu_mode=10. With overflow low, the next state is R-type write-back, which drives rf_we=1 with rf_dst_rd=1 and rf_from_mem=0.
- R8: Overflow is sampled only in execute. If it is high there, the next state is the overflow state, and rf_we is never asserted for that instruction. Overflow has no effect in any other state.
- R9: Branch completion drives opa_sel=1, opb_sel=00, alu_mode=01, pc_load_if_eq=1 and pc_mux=01.
- R10: Jump completion drives pc_load=1 with pc_mux=10.
- R11: The undefined-opcode state drives these signals high: ret_save, pc_load and reason_save. It drives opa_sel=0, opb_sel=01, alu_mode=01, pc_mux=11 and reason_code=0.
- R12: The overflow state drives the same word as R11, except that reason_code=1.
- R13: The load write-back, memory-write, R-type write-back, branch, jump and both fault states all return to fetch at the next edge.
- R14: In every state, any control signal not named for that state is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| opcode | input | 6 | Opcode field from the instruction register |
| overflow | input | 1 | ALU signed-overflow flag |
| ram_rd | output | 1 | Shared memory read enable |
| ram_wr | output | 1 | Shared memory write enable |
| instr_latch | output | 1 | Instruction register load |
| pc_load | output | 1 | Unconditional PC load |
| pc_load_if_eq | output | 1 | PC load when the ALU reports equal operands |
| addr_from_alu | output | 1 | Memory address from ALU result register (1) or PC (0) |
| rf_we | output | 1 | Register file write enable |
| rf_dst_rd | output | 1 | Destination is rd field (1) or rt field (0) |
| rf_from_mem | output | 1 | Write data from memory data register (1) or ALU result (0) |
| opa_sel | output | 1 | ALU operand A: register A (1) or PC (0) |
| opb_sel | output | 2 | ALU operand B: 00 register B, 01 constant 4, 10 immediate, 11 shifted immediate |
| alu_mode | output | 2 | 00 add, 01 subtract, 10 function-field operation |
| pc_mux | output | 2 | PC source: 00 ALU, 01 ALU result register, 10 jump target, 11 handler vector |
| ret_save | output | 1 | Return-address register write |
| reason_save | output | 1 | Reason register write |
| reason_code | output | 1 | Reason value: 0 undefined opcode, 1 overflow |

## Verification
The properties rely on two assumptions about the inputs. The opcode must stay stable from decode through the end of the instruction, as it does when driven from an instruction register. The overflow flag only matters in the execute cycle. The stimulus meets the first assumption by holding each opcode constant for the whole instruction. For the second, it drives overflow both high and low for every one of the 64 opcodes, so the flag appears in every state and the bench can confirm it is ignored everywhere except execute. A reset in the middle of an R-type instruction covers the reset-recovery path.

// File: rtl/mc_ctrl_pkg.sv
package mc_ctrl_pkg;

  localparam int ST_W = 4;

  typedef enum logic [ST_W-1:0] {
    ST_FETCH   = 4'd0,
    ST_DECODE  = 4'd1,
    ST_ADDR    = 4'd2,
    ST_MRD     = 4'd3,
    ST_LDWB    = 4'd4,
    ST_MWR     = 4'd5,
    ST_EXEC    = 4'd6,
    ST_RWB     = 4'd7,
    ST_BRANCH  = 4'd8,
    ST_JUMP    = 4'd9,
    ST_BADOP   = 4'd10,
    ST_OVF     = 4'd11
  } state_t;

  typedef struct packed {
    logic       ram_rd;
    logic       ram_wr;
    logic       instr_latch;
    logic       pc_load;
    logic       pc_load_if_eq;
    logic       addr_from_alu;
    logic       rf_we;
    logic       rf_dst_rd;
    logic       rf_from_mem;
    logic       opa_sel;
    logic [1:0] opb_sel;
    logic [1:0] alu_mode;
    logic [1:0] pc_mux;
    logic       ret_save;
    logic       reason_save;
    logic       reason_code;
  } ctrl_t;

endpackage

// File: rtl/mc_ctrl_next.sv
module mc_ctrl_next
  import mc_ctrl_pkg::*;
#(
  parameter int               OP_W     = 6,
  parameter logic [OP_W-1:0]  OP_RTYPE = 6'b000000,
  parameter logic [OP_W-1:0]  OP_LOAD  = 6'b100011,
  parameter logic [OP_W-1:0]  OP_STORE = 6'b101011,
  parameter logic [OP_W-1:0]  OP_BEQ   = 6'b000100,
  parameter logic [OP_W-1:0]  OP_JUMP  = 6'b000010
) (
  input  state_t          cur,
  input  logic [OP_W-1:0] opcode,
  input  logic            overflow,
  output state_t          nxt
);

  always_comb begin
    nxt = ST_FETCH;
    unique case (cur)
      ST_FETCH:  nxt = ST_DECODE;
      ST_DECODE: begin
        if (opcode == OP_LOAD || opcode == OP_STORE) nxt = ST_ADDR;
        else if (opcode == OP_RTYPE)                 nxt = ST_EXEC;
        else if (opcode == OP_BEQ)                   nxt = ST_BRANCH;
        else if (opcode == OP_JUMP)                  nxt = ST_JUMP;
        else                                         nxt = ST_BADOP;
      end
      ST_ADDR:   nxt = (opcode == OP_LOAD) ? ST_MRD : ST_MWR;
      ST_MRD:    nxt = ST_LDWB;
      ST_EXEC:   nxt = overflow ? ST_OVF : ST_RWB;
      default:   nxt = ST_FETCH;
    endcase
  end

endmodule

// File: rtl/mc_ctrl_decode.sv
module mc_ctrl_decode
  import mc_ctrl_pkg::*;
(
  input  state_t st,
  output ctrl_t  word
);

  always_comb begin
    word = '0;
    unique case (st)
      ST_FETCH: begin
        word.ram_rd      = 1'b1;
        word.instr_latch = 1'b1;
        word.pc_load     = 1'b1;
        word.opb_sel     = 2'b01;
      end
      ST_DECODE: word.opb_sel = 2'b11;
      ST_ADDR: begin
        word.opa_sel = 1'b1;
        word.opb_sel = 2'b10;
      end
      ST_MRD: begin
        word.ram_rd        = 1'b1;
        word.addr_from_alu = 1'b1;
      end
      ST_LDWB: begin
        word.rf_we       = 1'b1;
        word.rf_from_mem = 1'b1;
      end
      ST_MWR: begin
        word.ram_wr        = 1'b1;
        word.addr_from_alu = 1'b1;
      end
      ST_EXEC: begin
        word.opa_sel  = 1'b1;
        word.alu_mode = 2'b10;
      end
      ST_RWB: begin
        word.rf_we     = 1'b1;
        word.rf_dst_rd = 1'b1;
      end
      ST_BRANCH: begin
        word.opa_sel       = 1'b1;
        word.alu_mode      = 2'b01;
        word.pc_load_if_eq = 1'b1;
        word.pc_mux        = 2'b01;
      end
      ST_JUMP: begin
        word.pc_load = 1'b1;
        word.pc_mux  = 2'b10;
      end
      ST_BADOP, ST_OVF: begin
        word.opb_sel     = 2'b01;
        word.alu_mode    = 2'b01;
        word.ret_save    = 1'b1;
        word.pc_load     = 1'b1;
        word.reason_save = 1'b1;
        word.pc_mux      = 2'b11;
        word.reason_code = (st == ST_OVF);
      end
      default: word = '0;
    endcase
  end

endmodule

// File: rtl/mc_ctrl_fsm.sv
module mc_ctrl_fsm
  import mc_ctrl_pkg::*;
#(
  parameter int               OP_W     = 6,
  parameter logic [OP_W-1:0]  OP_RTYPE = 6'b000000,
  parameter logic [OP_W-1:0]  OP_LOAD  = 6'b100011,
  parameter logic [OP_W-1:0]  OP_STORE = 6'b101011,
  parameter logic [OP_W-1:0]  OP_BEQ   = 6'b000100,
  parameter logic [OP_W-1:0]  OP_JUMP  = 6'b000010
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [OP_W-1:0] opcode,
  input  logic            overflow,
  output logic            ram_rd,
  output logic            ram_wr,
  output logic            instr_latch,
  output logic            pc_load,
  output logic            pc_load_if_eq,
  output logic            addr_from_alu,
  output logic            rf_we,
  output logic            rf_dst_rd,
  output logic            rf_from_mem,
  output logic            opa_sel,
  output logic [1:0]      opb_sel,
  output logic [1:0]      alu_mode,
  output logic [1:0]      pc_mux,
  output logic            ret_save,
  output logic            reason_save,
  output logic            reason_code
);

  state_t state_q;
  state_t nxt;
  state_t target;
  ctrl_t  word_d;
  ctrl_t  word_q;

  mc_ctrl_next #(
    .OP_W(OP_W), .OP_RTYPE(OP_RTYPE), .OP_LOAD(OP_LOAD),
    .OP_STORE(OP_STORE), .OP_BEQ(OP_BEQ), .OP_JUMP(OP_JUMP)
  ) u_next (
    .cur      (state_q),
    .opcode   (opcode),
    .overflow (overflow),
    .nxt      (nxt)
  );

  // Reset steers the upcoming state to fetch; outputs are decoded from the
  // state being entered so the registered word matches the state register.
  assign target = rst ? ST_FETCH : nxt;

  mc_ctrl_decode u_decode (
    .st   (target),
    .word (word_d)
  );

  always_ff @(posedge clk) begin
    state_q <= target;
    word_q  <= word_d;
  end

  assign ram_rd        = word_q.ram_rd;
  assign ram_wr        = word_q.ram_wr;
  assign instr_latch   = word_q.instr_latch;
  assign pc_load       = word_q.pc_load;
  assign pc_load_if_eq = word_q.pc_load_if_eq;
  assign addr_from_alu = word_q.addr_from_alu;
  assign rf_we         = word_q.rf_we;
  assign rf_dst_rd     = word_q.rf_dst_rd;
  assign rf_from_mem   = word_q.rf_from_mem;
  assign opa_sel       = word_q.opa_sel;
  assign opb_sel       = word_q.opb_sel;
  assign alu_mode      = word_q.alu_mode;
  assign pc_mux        = word_q.pc_mux;
  assign ret_save      = word_q.ret_save;
  assign reason_save   = word_q.reason_save;
  assign reason_code   = word_q.reason_code;

endmodule

// File: rtl/mc_ctrl_fsm_checker.sv
module mc_ctrl_fsm_checker (
  input logic       clk,
  input logic       rst,
  input logic       overflow,
  input logic       ram_rd,
  input logic       ram_wr,
  input logic       instr_latch,
  input logic       pc_load,
  input logic       addr_from_alu,
  input logic       rf_we,
  input logic       rf_from_mem,
  input logic       opa_sel,
  input logic [1:0] opb_sel,
  input logic [1:0] alu_mode,
  input logic       reason_save,
  input logic       reason_code
);

  assert_reset_fetch_R1: assert property (@(posedge clk)
    $fell(rst) |-> (instr_latch && pc_load && ram_rd));

  assert_fetch_then_decode_R2: assert property (@(posedge clk) disable iff (rst)
    instr_latch |=> (opb_sel == 2'b11 && !instr_latch));

  assert_load_read_then_wb_R5: assert property (@(posedge clk) disable iff (rst)
    (ram_rd && addr_from_alu) |=> (rf_we && rf_from_mem));

  assert_no_rd_wr_overlap_R6: assert property (@(posedge clk) disable iff (rst)
    !(ram_rd && ram_wr));

  assert_ovf_diverts_R8: assert property (@(posedge clk) disable iff (rst)
    (opa_sel && alu_mode == 2'b10 && overflow) |=> (reason_save && reason_code && !rf_we));

  assert_exec_clean_writes_R7: assert property (@(posedge clk) disable iff (rst)
    (opa_sel && alu_mode == 2'b10 && !overflow) |=> (rf_we && !rf_from_mem));

  assert_fault_returns_R13: assert property (@(posedge clk) disable iff (rst)
    reason_save |=> instr_latch);

  assert_store_returns_R13: assert property (@(posedge clk) disable iff (rst)
    ram_wr |=> instr_latch);

endmodule

bind mc_ctrl_fsm mc_ctrl_fsm_checker u_chk (.*);

// File: tb/mc_ctrl_fsm_test.sv
`timescale 1ns/1ps
module mc_ctrl_fsm_test;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [5:0] opcode = '0;
  logic       overflow = 1'b0;
  logic ram_rd, ram_wr, instr_latch, pc_load, pc_load_if_eq, addr_from_alu;
  logic rf_we, rf_dst_rd, rf_from_mem, opa_sel, ret_save, reason_save, reason_code;
  logic [1:0] opb_sel, alu_mode, pc_mux;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  mc_ctrl_fsm uut (
    .clk(clk), .rst(rst), .opcode(opcode), .overflow(overflow),
    .ram_rd(ram_rd), .ram_wr(ram_wr), .instr_latch(instr_latch),
    .pc_load(pc_load), .pc_load_if_eq(pc_load_if_eq),
    .addr_from_alu(addr_from_alu), .rf_we(rf_we), .rf_dst_rd(rf_dst_rd),
    .rf_from_mem(rf_from_mem), .opa_sel(opa_sel), .opb_sel(opb_sel),
    .alu_mode(alu_mode), .pc_mux(pc_mux), .ret_save(ret_save),
    .reason_save(reason_save), .reason_code(reason_code)
  );

  // Word order: rd wr latch pcld pceq addr we dst frommem opa opb[2] alu[2] pcmux[2] ret rsave rcode
  function automatic logic [18:0] exp_word(input int st);
    logic [18:0] w;
    case (st)
      0:  w = {1'b1,1'b0,1'b1,1'b1,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,2'b01,2'b00,2'b00,1'b0,1'b0,1'b0};
      1:  w = {10'b0,2'b11,2'b00,2'b00,3'b000};
      2:  w = {9'b0,1'b1,2'b10,2'b00,2'b00,3'b000};
      3:  w = {1'b1,4'b0,1'b1,4'b0,6'b0,3'b000};
      4:  w = {6'b0,1'b1,1'b0,1'b1,1'b0,6'b0,3'b000};
      5:  w = {1'b0,1'b1,3'b0,1'b1,4'b0,6'b0,3'b000};
      6:  w = {9'b0,1'b1,2'b00,2'b10,2'b00,3'b000};
      7:  w = {6'b0,1'b1,1'b1,1'b0,1'b0,6'b0,3'b000};
      8:  w = {4'b0,1'b1,4'b0,1'b1,2'b00,2'b01,2'b01,3'b000};
      9:  w = {3'b0,1'b1,6'b0,2'b00,2'b00,2'b10,3'b000};
      10: w = {3'b0,1'b1,6'b0,2'b01,2'b01,2'b11,3'b110};
      11: w = {3'b0,1'b1,6'b0,2'b01,2'b01,2'b11,3'b111};
      default: w = '0;
    endcase
    return w;
  endfunction

  function automatic int exp_next(input int st, input logic [5:0] op, input bit ov);
    case (st)
      0: return 1;
      1: begin
        if (op == 6'b100011 || op == 6'b101011) return 2;
        if (op == 6'b000000) return 6;
        if (op == 6'b000100) return 8;
        if (op == 6'b000010) return 9;
        return 10;
      end
      2: return (op == 6'b100011) ? 3 : 5;
      3: return 4;
      6: return ov ? 11 : 7;
      default: return 0;
    endcase
  endfunction

  function automatic string tag_of(input int st, input int prev);
    if (st == 0 && prev >= 0) return "R13";
    case (st)
      0: return "R2";  1: return "R3";  2: return "R4";
      3, 4: return "R5"; 5: return "R6"; 6, 7: return "R7";
      8: return "R9";  9: return "R10"; 10: return "R11";
      11: return "R12"; default: return "R14";
    endcase
  endfunction

  function automatic logic [18:0] got_word();
    return {ram_rd, ram_wr, instr_latch, pc_load, pc_load_if_eq, addr_from_alu,
            rf_we, rf_dst_rd, rf_from_mem, opa_sel, opb_sel, alu_mode, pc_mux,
            ret_save, reason_save, reason_code};
  endfunction

  task automatic check_word(input int st, input string tag);
    checks++;
    if (got_word() !== exp_word(st)) begin
      errors++;
      $display("FAIL %s state %0d: actual %b expected %b (R14 word)", tag, st,
               got_word(), exp_word(st));
    end
  endtask

  task automatic run_instr(input logic [5:0] op, input bit ov);
    int st = 0;
    int prev;
    int n = 0;
    bit saw_we = 1'b0;
    opcode   = op;
    overflow = ov;
    do begin
      @(posedge clk);
      prev = st;
      st = exp_next(st, op, ov);
      @(negedge clk);
      check_word(st, tag_of(st, (st == 0) ? prev : -1));
      if (rf_we) saw_we = 1'b1;
      n++;
    end while (st != 0 && n < 8);
    if (op == 6'b000000 && ov) begin
      checks++;
      if (saw_we) begin
        errors++;
        $display("FAIL R8 op %b: actual rf_we seen 1 expected 0", op);
      end
    end
  endtask

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 100000 && !done) begin
      done = 1'b1;
      errors++;
      $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
      $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    check_word(0, "R1");
    rst = 1'b0;
    // R2..R12: sweep every opcode with overflow low and high (R8 ignore)
    for (int op = 0; op < 64; op++) begin
      for (int ov = 0; ov < 2; ov++) begin
        run_instr(op[5:0], ov[0]);
      end
    end
    // R1: reset in mid R-type returns to fetch
    opcode = 6'b000000;
    overflow = 1'b0;
    @(posedge clk);
    @(posedge clk);
    @(negedge clk);
    check_word(6, "R7");
    rst = 1'b1;
    @(posedge clk);
    @(negedge clk);
    check_word(0, "R1");
    rst = 1'b0;
    run_instr(6'b100011, 1'b1);
    done = 1'b1;
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule